// File: doc/BRIEF.md
# Receive Character Match Engine

This block sits in the receive path of a serial controller, after the character assembler. It compares each incoming character with three programmable compare characters. Each compare slot has its own action set, made of four bits: raise an interrupt, remove the character from the stream, halt the transmitter, and resume the transmitter. When a character matches several slots, the actions of all of them are combined. Characters that survive go out on a filtered stream one cycle after they arrive. Together with each surviving character, an 8-bit counter advances and can raise its own interrupt.

All configuration goes through a small four-address register port. The three compare characters and the three action sets share one window address. A select register picks which of the six is visible there. The transmitter gate is a two-state machine, `TX_RUN` and `TX_HALT`. It moves from `TX_RUN` to `TX_HALT` on a character whose combined actions ask for halt but not resume. It moves back from `TX_HALT` to `TX_RUN` on resume without halt. In every other case it stays where it is. Software flow pacing uses this gate: it halts and resumes the transmitter on control characters that the engine also deletes from the stream.

Top module: `rx_match_engine`

## Requirements
- R1: After reset `tx_enable` is 1, `out_valid`, `match_irq` and `count_irq` are 0, and every register address reads 0.
- R2: Address 0 is the select register. Bits 2:0 are stored and bits 7:3 read 0. Bit 0 set shows a compare character at address 1, and bit 0 clear shows an action set there. Bits 2:1 give the slot index 0..2. Index 3 makes address 1 read 0 and ignore writes.
- R3: Address 1 is the banked window. A compare character holds all 8 bits. An action set stores bits 3:0 and reads 0 in bits 7:4. Its fields are bit 0 interrupt, bit 1 delete, bit 2 halt and bit 3 resume.
- R4: A character accepted on `rx_valid` that equals the compare character of a slot whose interrupt bit is set makes `match_irq` 1 in the next cycle. `match_id` then holds 5'b11000 + k, where k is the lowest such slot (11000, 11001 or 11010).
- R5: A character whose matching slots have any delete bit set is not forwarded. Any other accepted character appears on `out_valid`/`out_char` in the next cycle.
- R6: Halt and resume bits are ORed over all matching slots. Halt only clears `tx_enable`, resume only sets it, and both together leave it unchanged. The change shows after the clock edge that accepts the character.
- R7: Address 3 reads the character counter. It advances by one for each forwarded character, wraps from 255 to 0, does not count deleted characters, and ignores writes.
- R8: Address 2 bit 0 enables the count interrupt. When it is set, `count_irq` is 1 in the cycle after each counter advance. When it is clear, `count_irq` stays 0.
- R9: A character matching no slot is forwarded unchanged, raises no `match_irq`, and leaves `tx_enable` unchanged.
- R10: In a cycle after one without `rx_valid`, `out_valid`, `match_irq` and `count_irq` are 0 and the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 select, 1 window, 2 control, 3 counter |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (combinational) |
| rx_valid | input | 1 | Received character present |
| rx_char | input | 8 | Received character |
| out_valid | output | 1 | Filtered character present |
| out_char | output | 8 | Filtered character |
| tx_enable | output | 1 | Transmitter gate, 1 = running |
| match_irq | output | 1 | Match interrupt pulse |
| match_id | output | 5 | Match interrupt code |
| count_irq | output | 1 | Counter-advance interrupt pulse |

## Verification
The bench sends all 256 character values through several slot setups. It compares every output with an arithmetic model of the slots. One case has several slots matching the same character. A priority encoder that searched the wrong way would report 11010 instead of 11001 or 11000. An engine that took only the first match's actions would lose a delete or a resume. A character that asks for halt and resume at once has to leave the gate where it was; a design that lets one bit win would flip `tx_enable`. The bench also counts the counter up to 255 and past it, so a non-wrapping or saturating counter would be caught. It writes to slot index 3 and to the read-only counter and expects no effect. It also sends deleted characters and checks that they neither leave the block nor advance the count.

// File: rtl/rme_pkg.sv
package rme_pkg;
    // Action-set field positions
    localparam int FN_W     = 4;
    localparam int FN_INT   = 0;
    localparam int FN_DEL   = 1;
    localparam int FN_HALT  = 2;
    localparam int FN_RESUME = 3;

    // Match interrupt code base, slot index is added
    localparam logic [4:0] MATCH_ID_BASE = 5'b11000;

    // Register addresses
    localparam logic [1:0] A_SEL = 2'd0;
    localparam logic [1:0] A_WIN = 2'd1;
    localparam logic [1:0] A_CTL = 2'd2;
    localparam logic [1:0] A_CNT = 2'd3;

    typedef enum logic [0:0] {
        TX_RUN  = 1'b0,
        TX_HALT = 1'b1
    } tx_state_e;
endpackage

// File: rtl/rme_bank.sv
module rme_bank
    import rme_pkg::*;
#(
    parameter int N_CMP = 3,
    parameter int DW    = 8,
    localparam int IW   = (N_CMP > 1) ? $clog2(N_CMP) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  addr,
    input  logic [DW-1:0]               wdata,
    input  logic [DW-1:0]               rx_char,
    output logic [DW-1:0]               sel_rd,
    output logic [DW-1:0]               win_rd,
    output logic [N_CMP-1:0]            hit,
    output logic [N_CMP-1:0][FN_W-1:0]  fn
);
    localparam logic [IW-1:0] LAST = IW'(N_CMP - 1);

    logic [IW:0]                  sel_q;
    logic [N_CMP-1:0][DW-1:0]     char_q;
    logic [N_CMP-1:0][FN_W-1:0]   fn_q;

    logic          sel_is_char;
    logic [IW-1:0] sel_idx;
    logic          sel_ok;

    assign sel_is_char = sel_q[0];
    assign sel_idx     = sel_q[IW:1];
    assign sel_ok      = (sel_idx <= LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            char_q <= '0;
            fn_q   <= '0;
        end else if (wr_en) begin
            if (addr == A_SEL) sel_q <= wdata[IW:0];
            if (addr == A_WIN && sel_ok) begin
                for (int k = 0; k < N_CMP; k++) begin
                    if (sel_idx == IW'(k)) begin
                        if (sel_is_char) char_q[k] <= wdata;
                        else             fn_q[k]   <= wdata[FN_W-1:0];
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_slot
        assign hit[g] = (rx_char == char_q[g]);
        assign fn[g]  = fn_q[g];
    end

    assign sel_rd = DW'(sel_q);

    always_comb begin
        win_rd = '0;
        for (int k = 0; k < N_CMP; k++) begin
            if (sel_idx == IW'(k))
                win_rd = sel_is_char ? char_q[k] : DW'(fn_q[k]);
        end
    end
endmodule

// File: rtl/rme_resolve.sv
module rme_resolve
    import rme_pkg::*;
#(
    parameter int N_CMP = 3,
    localparam int IW   = (N_CMP > 1) ? $clog2(N_CMP) : 1
) (
    input  logic                        valid,
    input  logic [N_CMP-1:0]            hit,
    input  logic [N_CMP-1:0][FN_W-1:0]  fn,
    output logic                        int_req,
    output logic [IW-1:0]               int_idx,
    output logic                        del,
    output logic                        halt,
    output logic                        resume
);
    // Walk from the top slot down so the lowest matching slot sets the code last
    always_comb begin
        int_req = 1'b0;
        int_idx = '0;
        del     = 1'b0;
        halt    = 1'b0;
        resume  = 1'b0;
        for (int k = N_CMP - 1; k >= 0; k--) begin
            if (valid && hit[k]) begin
                del    = del    | fn[k][FN_DEL];
                halt   = halt   | fn[k][FN_HALT];
                resume = resume | fn[k][FN_RESUME];
                if (fn[k][FN_INT]) begin
                    int_req = 1'b1;
                    int_idx = IW'(k);
                end
            end
        end
    end
endmodule

// File: rtl/rme_txgate.sv
module rme_txgate
    import rme_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic resume,
    output logic tx_enable
);
    tx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_RUN:  if (halt && !resume) state_d = TX_HALT;
            TX_HALT: if (resume && !halt) state_d = TX_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            TX_RUN:  tx_enable = 1'b1;
            TX_HALT: tx_enable = 1'b0;
        endcase
    end
endmodule

// File: rtl/rme_counter.sv
module rme_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/rx_match_engine.sv
module rx_match_engine
    import rme_pkg::*;
#(
    parameter int N_CMP = 3,
    parameter int DW    = 8,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_char,
    output logic          out_valid,
    output logic [DW-1:0] out_char,
    output logic          tx_enable,
    output logic          match_irq,
    output logic [4:0]    match_id,
    output logic          count_irq
);
    localparam int IW = (N_CMP > 1) ? $clog2(N_CMP) : 1;

    logic [DW-1:0]               sel_rd, win_rd;
    logic [N_CMP-1:0]            hit;
    logic [N_CMP-1:0][FN_W-1:0]  fn;
    logic                        int_req, del, halt, resume;
    logic [IW-1:0]               int_idx;
    logic                        fwd;
    logic                        cnt_irq_en;
    logic [CW-1:0]               cnt_val;

    rme_bank #(.N_CMP(N_CMP), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rx_char(rx_char), .sel_rd(sel_rd),
        .win_rd(win_rd), .hit(hit), .fn(fn)
    );

    rme_resolve #(.N_CMP(N_CMP)) u_resolve (
        .valid(rx_valid), .hit(hit), .fn(fn), .int_req(int_req),
        .int_idx(int_idx), .del(del), .halt(halt), .resume(resume)
    );

    rme_txgate u_txgate (
        .clk(clk), .rst_n(rst_n), .halt(halt), .resume(resume),
        .tx_enable(tx_enable)
    );

    assign fwd = rx_valid && !del;

    rme_counter #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(fwd), .count(cnt_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_irq_en <= 1'b0;
            out_valid  <= 1'b0;
            out_char   <= '0;
            match_irq  <= 1'b0;
            match_id   <= '0;
            count_irq  <= 1'b0;
        end else begin
            if (cfg_wr && cfg_addr == A_CTL) cnt_irq_en <= cfg_wdata[0];
            out_valid <= fwd;
            out_char  <= rx_char;
            match_irq <= int_req;
            match_id  <= MATCH_ID_BASE | 5'(int_idx);
            count_irq <= fwd && cnt_irq_en;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            A_SEL: cfg_rdata = sel_rd;
            A_WIN: cfg_rdata = win_rd;
            A_CTL: cfg_rdata = DW'(cnt_irq_en);
            A_CNT: cfg_rdata = DW'(cnt_val);
        endcase
    end
endmodule

// File: rtl/rme_checker.sv
module rme_checker #(
    parameter int N_CMP = 3,
    parameter int DW    = 8,
    parameter int CW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [DW-1:0] rx_char,
    input logic          out_valid,
    input logic [DW-1:0] out_char,
    input logic          tx_enable,
    input logic          match_irq,
    input logic [4:0]    match_id,
    input logic          count_irq,
    input logic [CW-1:0] count
);
    a_r5_fwd_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rx_valid));

    a_r5_char_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_char == $past(rx_char));

    a_r4_id_code: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> (match_id[4:3] == 2'b11 && match_id[2:0] <= 3'(N_CMP - 1)));

    a_r4_irq_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> $past(rx_valid));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> count == CW'($past(count) + 1'b1));

    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(count));

    a_r8_irq_with_advance: assert property (@(posedge clk) disable iff (!rst_n)
        count_irq |-> out_valid);

    a_r10_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> $stable(tx_enable));
endmodule

bind rx_match_engine rme_checker #(.N_CMP(N_CMP), .DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .out_valid(out_valid), .out_char(out_char), .tx_enable(tx_enable),
    .match_irq(match_irq), .match_id(match_id), .count_irq(count_irq),
    .count(cnt_val)
);

// File: tb/sim_rx_match_engine.sv
`timescale 1ns/1ps
module sim_rx_match_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = 8'd0;
    logic       out_valid;
    logic [7:0] out_char;
    logic       tx_enable;
    logic       match_irq;
    logic [4:0] match_id;
    logic       count_irq;

    always #10 clk = ~clk;

    rx_match_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_valid(rx_valid),
        .rx_char(rx_char), .out_valid(out_valid), .out_char(out_char),
        .tx_enable(tx_enable), .match_irq(match_irq), .match_id(match_id),
        .count_irq(count_irq)
    );

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    logic [7:0] m_ch [3];
    logic [3:0] m_fn [3];
    logic       m_cnt_en = 1'b0;
    logic [7:0] exp_cnt = 8'd0;
    logic       exp_tx = 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp,
                      input string req, input string what);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == exp, req, what, cfg_rdata, exp);
    endtask

    task automatic set_slot(input int k, input logic [7:0] c, input logic [3:0] f);
        wr(2'd0, {5'd0, 2'(k), 1'b1});
        wr(2'd1, c);
        wr(2'd0, {5'd0, 2'(k), 1'b0});
        wr(2'd1, {4'd0, f});
        m_ch[k] = c;
        m_fn[k] = f;
    endtask

    task automatic push(input logic [7:0] c);
        bit e_int, e_del, e_halt, e_res, e_fwd;
        logic [4:0] e_id;
        e_int = 0; e_del = 0; e_halt = 0; e_res = 0; e_id = 5'd0;
        for (int k = 2; k >= 0; k--) begin
            if (c == m_ch[k]) begin
                e_del  = e_del  | m_fn[k][1];
                e_halt = e_halt | m_fn[k][2];
                e_res  = e_res  | m_fn[k][3];
                if (m_fn[k][0]) begin
                    e_int = 1;
                    e_id  = 5'd24 + 5'(k);
                end
            end
        end
        e_fwd = !e_del;
        if (e_fwd) exp_cnt = exp_cnt + 8'd1;
        if (e_halt && !e_res) exp_tx = 1'b0;
        else if (e_res && !e_halt) exp_tx = 1'b1;
        rx_valid = 1'b1; rx_char = c;
        @(negedge clk);
        rx_valid = 1'b0;
        cfg_addr = 2'd3;
        #1;
        chk(out_valid == e_fwd, "R5", "out_valid", out_valid, e_fwd);
        if (e_fwd) chk(out_char == c, "R9", "out_char", out_char, c);
        chk(match_irq == e_int, "R4", "match_irq", match_irq, e_int);
        if (e_int) chk(match_id == e_id, "R4", "match_id", match_id, e_id);
        chk(count_irq == (e_fwd && m_cnt_en), "R8", "count_irq", count_irq,
            e_fwd && m_cnt_en);
        chk(tx_enable == exp_tx, "R6", "tx_enable", tx_enable, exp_tx);
        chk(cfg_rdata == exp_cnt, "R7", "count", cfg_rdata, exp_cnt);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            m_ch[k] = 8'd0; m_fn[k] = 4'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(tx_enable == 1'b1, "R1", "tx_enable", tx_enable, 1);
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(match_irq == 1'b0, "R1", "match_irq", match_irq, 0);
        chk(count_irq == 1'b0, "R1", "count_irq", count_irq, 0);
        for (int a = 0; a < 4; a++) rd(2'(a), 8'd0, "R1", "reg after reset");

        // R2/R3: banked access sweep, index 3 included
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, {5'd0, 2'(k), 1'b1});
            wr(2'd1, 8'hC0 | 8'(k));
            wr(2'd0, {5'd0, 2'(k), 1'b0});
            wr(2'd1, 8'hF0 | 8'(k + 5));
            if (k < 3) begin
                m_ch[k] = 8'hC0 | 8'(k);
                m_fn[k] = 4'(k + 5);
            end
        end
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, {5'd0, 2'(k), 1'b1});
            rd(2'd0, {5'd0, 2'(k), 1'b1}, "R2", "select readback");
            rd(2'd1, (k < 3) ? (8'hC0 | 8'(k)) : 8'd0, "R2", "char window");
            wr(2'd0, {5'd0, 2'(k), 1'b0});
            rd(2'd1, (k < 3) ? 8'(k + 5) : 8'd0, "R3", "action window");
        end
        wr(2'd0, 8'hFF);
        rd(2'd0, 8'h07, "R2", "select upper bits");

        // Setup A: single matches, enable count interrupt
        set_slot(0, 8'h41, 4'b0001);
        set_slot(1, 8'h13, 4'b0110);
        set_slot(2, 8'h11, 4'b1011);
        wr(2'd2, 8'h01); m_cnt_en = 1'b1;
        rd(2'd2, 8'h01, "R8", "control readback");
        for (int c = 0; c < 256; c++) push(8'(c));

        // Overlapping matches: priority and combined actions
        set_slot(0, 8'h55, 4'b0100);
        set_slot(1, 8'h55, 4'b0001);
        set_slot(2, 8'h55, 4'b1001);
        push(8'h55);              // R6 halt+resume together keeps gate, R4 code 11001
        set_slot(0, 8'h55, 4'b0011);
        push(8'h55);              // R4 code 11000, R5 deleted, R6 resume
        set_slot(1, 8'h55, 4'b0100);
        set_slot(2, 8'h55, 4'b0000);
        push(8'h55);              // R6 halt via slot 1 while slot 0 deletes
        for (int c = 0; c < 256; c++) push(8'(c));

        // R7 wrap with count interrupt off
        wr(2'd2, 8'h00); m_cnt_en = 1'b0;
        while (exp_cnt != 8'hFF) push(8'h20);
        push(8'h20);
        chk(exp_cnt == 8'h00, "R7", "model wrap", exp_cnt, 0);

        // R7 write to counter ignored
        wr(2'd3, 8'h5A);
        rd(2'd3, exp_cnt, "R7", "count after write");

        // R10 idle cycle
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R10", "idle out_valid", out_valid, 0);
        chk(match_irq == 1'b0, "R10", "idle match_irq", match_irq, 0);
        chk(count_irq == 1'b0, "R10", "idle count_irq", count_irq, 0);
        rd(2'd3, exp_cnt, "R10", "idle count");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule